// File: doc/BRIEF.md
# Timer Run and Interrupt Flag Control Register

This block is the byte-wide control and status register found beside a pair of timer/counters and two external interrupt inputs in an 8051-style microcontroller. Software reads and writes it through a special-function-register port. The two run bits start and stop the timers. Four flags record pending events: two timer overflows and two external interrupts. Hardware sets and clears these flags according to rules that depend on the source.

Timer flags are set by an overflow pulse from the counter. They are cleared when the core acknowledges the vector. Each external input is active low and can run in one of two modes. In edge mode a falling edge latches a flag, and the acknowledge clears it. In level mode the flag simply mirrors the synchronized pin, inverted. Each flag is gated with its own enable and with a global enable, which produces four interrupt request lines for a separate priority resolver.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset the register reads 0x00, both run outputs are 0 and all four requests are 0.
- R2: The register layout is: bit 7 timer-1 flag, bit 6 timer-1 run, bit 5 timer-0 flag, bit 4 timer-0 run, bit 3 external-1 flag, bit 2 external-1 type, bit 1 external-0 flag, bit 0 external-0 type. A write loads all eight bits, except that the hardware rules below take priority for flags. The value written reads back on the cycle after the write.
- R3: tmrRun[0] equals bit 4 and tmrRun[1] equals bit 6, and neither changes without a write.
- R4: A one-cycle pulse on tmrOvf[i] sets the matching timer flag at the next clock edge. The flag then stays set.
- R5: A pulse on ackTmr[i] clears the matching timer flag at the next clock edge.
- R6: With the type bit at 1 (edge mode), a falling edge on extIntN[i] sets the external flag at the third clock edge after the pin changes. This delay comes from two synchronizer flops plus the flag register. A pin held low does not set the flag again after a clear, and a rising edge has no effect.
- R7: In edge mode, a pulse on ackExt[i] clears the external flag.
- R8: With the type bit at 0 (level mode), the external flag equals the inverted synchronized pin, with the same three-edge delay. Acknowledges and software writes do not change it.
- R9: A hardware set and a software write of 0 to the same flag in the same cycle leave the flag set.
- R10: A hardware set and an acknowledge clear of the same flag in the same cycle leave the flag set.
- R11: irqReq[0] is timer 0, irqReq[1] is timer 1, irqReq[2] is external 0 and irqReq[3] is external 1. Each request is its flag ANDed with its own enable (ienTmr[i] or ienExt[i]) and with ienGlobal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrWrEn | input | 1 | Register write strobe |
| sfrWrData | input | 8 | Register write data |
| sfrRdData | output | 8 | Register read data |
| tmrOvf | input | 2 | Overflow pulses from timers 1 and 0 |
| extIntN | input | 2 | Active-low external interrupt pins |
| ackTmr | input | 2 | Vector acknowledge for the timer interrupts |
| ackExt | input | 2 | Vector acknowledge for the external interrupts |
| ienGlobal | input | 1 | Global interrupt enable |
| ienTmr | input | 2 | Individual timer interrupt enables |
| ienExt | input | 2 | Individual external interrupt enables |
| tmrRun | output | 2 | Run enables to timers 1 and 0 |
| irqReq | output | 4 | Gated interrupt requests |

## Verification
The bench targets collisions on a single cycle: an overflow arriving together with a software write of zero, or together with an acknowledge. A design with the wrong priority would lose the overflow and the flag would read back clear.

It also checks the external flag's exact timing. It samples one cycle before and on the third edge after the pin falls, which catches a missing or extra synchronizer stage. In edge mode it holds the pin low after an acknowledge, which exposes a level-sensitive detector that keeps setting the flag again. In level mode it sends acknowledges and writes of zero, which would wrongly clear a flag that must track the pin.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NUM_SRC = 2;
  localparam int REG_W   = 8;

  // Bit positions are fixed by the register layout the core decodes.
  function automatic int tfPos(input int i); return 5 + 2 * i; endfunction
  function automatic int trPos(input int i); return 4 + 2 * i; endfunction
  function automatic int iePos(input int i); return 1 + 2 * i; endfunction
  function automatic int itPos(input int i); return 2 * i;     endfunction

  typedef struct packed {
    logic [NUM_SRC-1:0] setTf;
    logic [NUM_SRC-1:0] clrTf;
    logic [NUM_SRC-1:0] setIe;
    logic [NUM_SRC-1:0] clrIe;
    logic [NUM_SRC-1:0] lvlMode;
    logic [NUM_SRC-1:0] lvlVal;
    logic               wrEn;
    logic [REG_W-1:0]   wrData;
  } ctlStrobes_t;
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sfrWrEn,
  input  logic [REG_W-1:0]   sfrWrData,
  input  logic [NUM_SRC-1:0] tmrOvf,
  input  logic [NUM_SRC-1:0] extIntN,
  input  logic [NUM_SRC-1:0] ackTmr,
  input  logic [NUM_SRC-1:0] ackExt,
  input  logic [NUM_SRC-1:0] modeEdge,
  output ctlStrobes_t        strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] pinSynced;
  logic [NUM_SRC-1:0] pinPrev;
  logic [NUM_SRC-1:0] fallSeen;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], extIntN[i]};
    end
    assign pinSynced[i] = chain[LAST];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '1;
    else       pinPrev <= pinSynced;
  end

  assign fallSeen = pinPrev & ~pinSynced;

  always_comb begin
    strb         = '0;
    strb.wrEn    = sfrWrEn;
    strb.wrData  = sfrWrData;
    strb.setTf   = tmrOvf;
    strb.clrTf   = ackTmr;
    strb.setIe   = fallSeen & modeEdge;
    strb.clrIe   = ackExt & modeEdge;
    strb.lvlMode = ~modeEdge;
    strb.lvlVal  = ~pinSynced;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_edge_set_only_in_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
      strb.setIe[i] |-> modeEdge[i]);
    assert_level_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
      !modeEdge[i] |-> !strb.clrIe[i]);
  end
endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic               ienGlobal,
  input  logic [NUM_SRC-1:0] ienTmr,
  input  logic [NUM_SRC-1:0] ienExt,
  output logic [REG_W-1:0]   regByte,
  output logic [NUM_SRC-1:0] modeEdge,
  output logic [NUM_SRC-1:0] tmrRun,
  output logic [2*NUM_SRC-1:0] irqReq
);
  logic [REG_W-1:0] regNext;

  always_comb begin
    regNext = regByte;
    if (strb.wrEn) regNext = strb.wrData;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.setTf[i])      regNext[tfPos(i)] = 1'b1;
      else if (strb.clrTf[i]) regNext[tfPos(i)] = 1'b0;
      if (strb.lvlMode[i])    regNext[iePos(i)] = strb.lvlVal[i];
      else if (strb.setIe[i]) regNext[iePos(i)] = 1'b1;
      else if (strb.clrIe[i]) regNext[iePos(i)] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regByte <= '0;
    else       regByte <= regNext;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_out
    assign modeEdge[i]        = regByte[itPos(i)];
    assign tmrRun[i]          = regByte[trPos(i)];
    assign irqReq[i]          = regByte[tfPos(i)] & ienTmr[i] & ienGlobal;
    assign irqReq[NUM_SRC+i]  = regByte[iePos(i)] & ienExt[i] & ienGlobal;

    assert_tf_set_R4: assert property (@(posedge clk) disable iff (!rstN)
      strb.setTf[i] |=> regByte[tfPos(i)]);
    assert_tf_ack_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrTf[i] && !strb.setTf[i] |=> !regByte[tfPos(i)]);
    assert_set_beats_write_R9: assert property (@(posedge clk) disable iff (!rstN)
      strb.setTf[i] && strb.wrEn && !strb.wrData[tfPos(i)] |=> regByte[tfPos(i)]);
    assert_level_track_R8: assert property (@(posedge clk) disable iff (!rstN)
      strb.lvlMode[i] |=> regByte[iePos(i)] == $past(strb.lvlVal[i]));
  end

  assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(tmrRun));
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
  import tmr_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sfrWrEn,
  input  logic [7:0] sfrWrData,
  output logic [7:0] sfrRdData,
  input  logic [1:0] tmrOvf,
  input  logic [1:0] extIntN,
  input  logic [1:0] ackTmr,
  input  logic [1:0] ackExt,
  input  logic       ienGlobal,
  input  logic [1:0] ienTmr,
  input  logic [1:0] ienExt,
  output logic [1:0] tmrRun,
  output logic [3:0] irqReq
);
  ctlStrobes_t        strb;
  logic [NUM_SRC-1:0] modeEdge;

  tmr_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData),
    .tmrOvf(tmrOvf), .extIntN(extIntN), .ackTmr(ackTmr), .ackExt(ackExt),
    .modeEdge(modeEdge), .strb(strb)
  );

  tmr_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ienGlobal(ienGlobal),
    .ienTmr(ienTmr), .ienExt(ienExt), .regByte(sfrRdData),
    .modeEdge(modeEdge), .tmrRun(tmrRun), .irqReq(irqReq)
  );

  assert_irq_needs_global_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|irqReq) |-> ienGlobal);
  assert_irq_flag_backed_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqReq[0] |-> sfrRdData[5] && ienTmr[0]);
endmodule

// File: tb/tmr_irq_ctl_tb.sv
module tmr_irq_ctl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sfrWrEn = 1'b0;
  logic [7:0] sfrWrData = '0;
  logic [7:0] sfrRdData;
  logic [1:0] tmrOvf = '0;
  logic [1:0] extIntN = 2'b11;
  logic [1:0] ackTmr = '0;
  logic [1:0] ackExt = '0;
  logic       ienGlobal = 1'b0;
  logic [1:0] ienTmr = '0;
  logic [1:0] ienExt = '0;
  logic [1:0] tmrRun;
  logic [3:0] irqReq;

  int nChecks = 0;
  int nFails  = 0;
  bit timedOut = 0;

  always #5 clk = ~clk;

  tmr_irq_ctl u_dut (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData),
    .sfrRdData(sfrRdData), .tmrOvf(tmrOvf), .extIntN(extIntN),
    .ackTmr(ackTmr), .ackExt(ackExt), .ienGlobal(ienGlobal),
    .ienTmr(ienTmr), .ienExt(ienExt), .tmrRun(tmrRun), .irqReq(irqReq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wrReg(input logic [7:0] v);
    sfrWrEn = 1'b1; sfrWrData = v; tick(); sfrWrEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 reg", sfrRdData, 8'h00);
    chk("R1 run", {6'b0, tmrRun}, 8'h00);
    chk("R1 irq", {4'b0, irqReq}, 8'h00);
  endtask

  task automatic tWrite();
    wrReg(8'h50);
    chk("R2 readback 50", sfrRdData, 8'h50);
    chk("R3 run both", {6'b0, tmrRun}, 8'h03);
    tick(); tick();
    chk("R3 run holds", {6'b0, tmrRun}, 8'h03);
    wrReg(8'h10);
    chk("R3 run0 only", {6'b0, tmrRun}, 8'h01);
    wrReg(8'hF5);   // level mode active during write, pins high: IE bits stay 0
    chk("R2 readback F5", sfrRdData, 8'hF5);
    wrReg(8'h00);   // edge mode during write, IE written 0
    chk("R2 clear", sfrRdData, 8'h00);
  endtask

  task automatic tTimer();
    ienGlobal = 1'b1; ienTmr = 2'b11; ienExt = 2'b11;
    tmrOvf = 2'b01; tick(); tmrOvf = '0;
    chk("R4 tf0 set", sfrRdData, 8'h20);
    chk("R11 irq tmr0", {4'b0, irqReq}, 8'h01);
    tick(); tick();
    chk("R4 tf0 sticky", sfrRdData, 8'h20);
    ackTmr = 2'b01; tick(); ackTmr = '0;
    chk("R5 tf0 cleared", sfrRdData, 8'h00);
    tmrOvf = 2'b10; tick(); tmrOvf = '0;
    chk("R4 tf1 set", sfrRdData, 8'h80);
    chk("R11 irq tmr1", {4'b0, irqReq}, 8'h02);
    ackTmr = 2'b10; tick(); ackTmr = '0;
    chk("R5 tf1 cleared", sfrRdData, 8'h00);
  endtask

  task automatic tGating();
    tmrOvf = 2'b01; tick(); tmrOvf = '0;
    ienGlobal = 1'b0; ienTmr = 2'b01; #1;
    chk("R11 no global", {4'b0, irqReq}, 8'h00);
    ienGlobal = 1'b1; ienTmr = 2'b10; #1;
    chk("R11 no indiv", {4'b0, irqReq}, 8'h00);
    ienTmr = 2'b01; #1;
    chk("R11 both on", {4'b0, irqReq}, 8'h01);
    ienTmr = 2'b11;
    ackTmr = 2'b01; tick(); ackTmr = '0;
  endtask

  task automatic tCollide();
    tmrOvf = 2'b01; sfrWrEn = 1'b1; sfrWrData = 8'h00; tick();
    tmrOvf = '0; sfrWrEn = 1'b0;
    chk("R9 set beats write", sfrRdData, 8'h20);
    tmrOvf = 2'b01; ackTmr = 2'b01; tick(); tmrOvf = '0; ackTmr = '0;
    chk("R10 set beats ack", sfrRdData, 8'h20);
    ackTmr = 2'b01; tick(); ackTmr = '0;
    chk("R5 clear after collide", sfrRdData, 8'h00);
  endtask

  task automatic tEdge();
    wrReg(8'h05);
    extIntN[0] = 1'b0; tick(); tick();
    chk("R6 not yet", sfrRdData, 8'h05);
    tick();
    chk("R6 ie0 set", sfrRdData, 8'h07);
    chk("R11 irq ext0", {4'b0, irqReq}, 8'h04);
    ackExt = 2'b01; tick(); ackExt = '0;
    chk("R7 ie0 cleared", sfrRdData, 8'h05);
    tick(); tick(); tick();
    chk("R6 held low no retrigger", sfrRdData, 8'h05);
    extIntN[0] = 1'b1; tick(); tick(); tick(); tick();
    chk("R6 rising ignored", sfrRdData, 8'h05);
    extIntN[1] = 1'b0; tick(); tick(); tick();
    chk("R6 ie1 set", sfrRdData, 8'h0D);
    chk("R11 irq ext1", {4'b0, irqReq}, 8'h08);
    ackExt = 2'b10; tick(); ackExt = '0;
    chk("R7 ie1 cleared", sfrRdData, 8'h05);
    extIntN[1] = 1'b1; tick(); tick(); tick();
  endtask

  task automatic tLevel();
    wrReg(8'h00);
    extIntN[0] = 1'b0; tick(); tick();
    chk("R8 not yet", sfrRdData, 8'h00);
    tick();
    chk("R8 follows low", sfrRdData, 8'h02);
    ackExt = 2'b01; tick(); ackExt = '0;
    chk("R8 ack ignored", sfrRdData, 8'h02);
    wrReg(8'h00);
    chk("R8 write ignored", sfrRdData, 8'h02);
    extIntN[0] = 1'b1; tick(); tick(); tick();
    chk("R8 follows high", sfrRdData, 8'h00);
  endtask

  initial begin
    fork
      begin
        tick(); tick();
        rstN = 1'b1;
        tick();
        tReset();
        tWrite();
        tTimer();
        tGating();
        tCollide();
        tEdge();
        tLevel();
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule